// File: doc/BRIEF.md
# Configuration Port Key Lock and Index/Data Register Window

This block is the configuration front end of a legacy I/O companion device. It uses two adjacent byte addresses on a simple strobe bus. A write to the lower address (the index port) chooses a configuration register. A read or write at the address one above it (the data port) then reaches that register. Configuration space starts out hidden. Only a doubled entry key written to the index port opens it, and an exit key written to the same port hides it again.

Once the space is open, the block provides a writable logical device number, and read-only manufacturer, device and revision identifiers. Multi-byte identifiers are stored high byte first at ascending indices. Indices from 0x30 upward form a banked window. When the general-purpose I/O logical device is selected, accesses in this window pass straight through to that device's port. The port carries a select strobe, a write flag, the index byte and the write byte. The device returns its read byte in the same cycle.

Top module: `sio_cfg_port`

## Requirements
- R1: After synchronous reset the port is locked, the logical device number is 0x00, the index register is 0x00 and `io_rvalid` is low.
- R2: While locked, any read of the index or data port returns 0xFF. Data-port writes change nothing, no forward strobe is raised, and index writes other than the keys leave the index register unchanged.
- R3: Only two consecutive index-port writes of 0x87 unlock the port. A single 0x87 leaves it locked.
- R4: Any index-port write other than 0x87 that falls between the two 0x87 writes restarts the key sequence, so one more 0x87 does not unlock.
- R5: An index-port write of 0xAA while unlocked locks the port again, and 0xAA is not stored as an index.
- R6: The index port is at `BASE_ADDR` (0x2E or 0x4E) and the data port at `BASE_ADDR`+1. While unlocked, reading the index port returns the current index. Accesses at any other address give no `io_rvalid` and change no state.
- R7: Index 0x07 holds the logical device number, which can be read and written through the data port.
- R8: Indices 0x20 and 0x21 return the device ID high byte and low byte, and index 0x22 returns the revision. Writes to them are ignored.
- R9: Indices 0x23 and 0x24 return the manufacturer ID high byte (0x19) and low byte (0x34).
- R10: While unlocked, with logical device 0x06 selected and index 0x30 or above, a data-port access raises `gd_sel` in the same cycle. `gd_we` is high for a write, `gd_idx` carries the index and `gd_wdata` the write byte. A read returns the `gd_rdata` value sampled in that cycle.
- R11: With any other logical device selected, a data-port access at index 0x30 or above raises no strobe and reads 0xFF.
- R12: Read data appears on `io_rdata` with `io_rvalid` high exactly one cycle after a read strobe to either port. An index below 0x30 that is not listed above reads 0xFF and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_rd | input | 1 | One-cycle read strobe |
| io_wr | input | 1 | One-cycle write strobe |
| io_addr | input | ADDR_W | Bus byte address |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Registered read byte |
| io_rvalid | output | 1 | Read byte valid, one cycle after the strobe |
| gd_sel | output | 1 | Forward strobe to the GPIO logical device |
| gd_we | output | 1 | Forwarded access is a write |
| gd_idx | output | 8 | Forwarded register index |
| gd_wdata | output | 8 | Forwarded write byte |
| gd_rdata | input | 8 | GPIO device read byte, valid while gd_sel is high |

## Verification
The assertions assume that a read strobe and a write strobe never arrive in the same cycle. They also assume that the attached GPIO device drives `gd_rdata` combinationally while `gd_sel` is high. The stimulus issues at most one strobe per cycle, always with a deasserted cycle in between. It models the device as a fixed function of `gd_idx`, so the returned byte is known in the strobe cycle. Key sequences are deliberately broken by stray index writes, and by writes to neighbouring addresses that must not count as keys.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  typedef logic [7:0] byte_t;

  localparam byte_t KEY_ENTER = 8'h87;
  localparam byte_t KEY_EXIT  = 8'hAA;
  localparam byte_t IX_LDN    = 8'h07;
  localparam byte_t IX_DID_HI = 8'h20;
  localparam byte_t IX_DID_LO = 8'h21;
  localparam byte_t IX_REV    = 8'h22;
  localparam byte_t IX_MID_HI = 8'h23;
  localparam byte_t IX_MID_LO = 8'h24;
  localparam byte_t IX_BANK   = 8'h30;
  localparam byte_t IDLE_BYTE = 8'hFF;

  typedef enum logic [1:0] {
    GATE_SHUT,
    GATE_HALF,
    GATE_OPEN
  } gate_st_t;

  typedef enum logic [2:0] {
    SEL_LDN,
    SEL_DID_HI,
    SEL_DID_LO,
    SEL_REV,
    SEL_MID_HI,
    SEL_MID_LO,
    SEL_BANK,
    SEL_NONE
  } sel_t;
endpackage

// File: rtl/sio_key_gate.sv
module sio_key_gate
  import sio_cfg_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  idx_wr,
  input  byte_t wbyte,
  output logic  locked
);
  gate_st_t st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= GATE_SHUT;
    end else if (idx_wr) begin
      unique case (st_q)
        GATE_SHUT: st_q <= (wbyte == KEY_ENTER) ? GATE_HALF : GATE_SHUT;
        GATE_HALF: st_q <= (wbyte == KEY_ENTER) ? GATE_OPEN : GATE_SHUT;
        GATE_OPEN: st_q <= (wbyte == KEY_EXIT)  ? GATE_SHUT : GATE_OPEN;
        default:   st_q <= GATE_SHUT;
      endcase
    end
  end

  assign locked = (st_q != GATE_OPEN);
endmodule

// File: rtl/sio_idx_decode.sv
module sio_idx_decode
  import sio_cfg_pkg::*;
#(
  parameter byte_t GPIO_LDN = 8'h06
) (
  input  byte_t idx,
  input  byte_t ldn,
  output sel_t  sel
);
  always_comb begin
    sel = SEL_NONE;
    if (idx >= IX_BANK) begin
      if (ldn == GPIO_LDN) sel = SEL_BANK;
    end else begin
      unique case (idx)
        IX_LDN:    sel = SEL_LDN;
        IX_DID_HI: sel = SEL_DID_HI;
        IX_DID_LO: sel = SEL_DID_LO;
        IX_REV:    sel = SEL_REV;
        IX_MID_HI: sel = SEL_MID_HI;
        IX_MID_LO: sel = SEL_MID_LO;
        default:   sel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h002E,
  parameter logic [15:0]       DEV_ID    = 16'h0A55,
  parameter byte_t             REV_ID    = 8'h11,
  parameter logic [15:0]       MFR_ID    = 16'h1934,
  parameter byte_t             GPIO_LDN  = 8'h06
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              io_rvalid,
  output logic              gd_sel,
  output logic              gd_we,
  output logic [7:0]        gd_idx,
  output logic [7:0]        gd_wdata,
  input  logic [7:0]        gd_rdata
);
  localparam logic [ADDR_W-1:0] DAT_ADDR = BASE_ADDR + ADDR_W'(1);

  logic  hit_idx, hit_dat, locked;
  byte_t idx_q, ldn_q, rd_byte;
  sel_t  sel;

  assign hit_idx = (io_addr == BASE_ADDR);
  assign hit_dat = (io_addr == DAT_ADDR);

  sio_key_gate u_gate (
    .clk    (clk),
    .rst    (rst),
    .idx_wr (io_wr && hit_idx),
    .wbyte  (io_wdata),
    .locked (locked)
  );

  sio_idx_decode #(.GPIO_LDN(GPIO_LDN)) u_dec (
    .idx (idx_q),
    .ldn (ldn_q),
    .sel (sel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      ldn_q <= '0;
    end else begin
      if (io_wr && hit_idx && !locked && io_wdata != KEY_EXIT) idx_q <= io_wdata;
      if (io_wr && hit_dat && !locked && sel == SEL_LDN)       ldn_q <= io_wdata;
    end
  end

  assign gd_sel   = (io_rd || io_wr) && hit_dat && !locked && (sel == SEL_BANK);
  assign gd_we    = gd_sel && io_wr;
  assign gd_idx   = idx_q;
  assign gd_wdata = io_wdata;

  always_comb begin
    rd_byte = IDLE_BYTE;
    if (!locked) begin
      if (hit_idx) begin
        rd_byte = idx_q;
      end else begin
        unique case (sel)
          SEL_LDN:    rd_byte = ldn_q;
          SEL_DID_HI: rd_byte = DEV_ID[15:8];
          SEL_DID_LO: rd_byte = DEV_ID[7:0];
          SEL_REV:    rd_byte = REV_ID;
          SEL_MID_HI: rd_byte = MFR_ID[15:8];
          SEL_MID_LO: rd_byte = MFR_ID[7:0];
          SEL_BANK:   rd_byte = gd_rdata;
          default:    rd_byte = IDLE_BYTE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rvalid <= 1'b0;
      io_rdata  <= '0;
    end else begin
      io_rvalid <= io_rd && (hit_idx || hit_dat);
      if (io_rd && (hit_idx || hit_dat)) io_rdata <= rd_byte;
    end
  end
endmodule

// File: rtl/sio_cfg_chk.sv
module sio_cfg_chk #(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h002E
) (
  input logic              clk,
  input logic              rst,
  input logic              io_rd,
  input logic              io_wr,
  input logic [ADDR_W-1:0] io_addr,
  input logic [7:0]        io_wdata,
  input logic [7:0]        io_rdata,
  input logic              io_rvalid,
  input logic              gd_sel,
  input logic              gd_we,
  input logic              locked,
  input logic [7:0]        ldn_q,
  input logic [7:0]        idx_q
);
  localparam logic [ADDR_W-1:0] DAT_ADDR = BASE_ADDR + ADDR_W'(1);

  logic rst_q;
  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst_q) begin
      p_reset_state_r1: assert (locked && ldn_q == 8'h00 && !io_rvalid);
    end
  end

  p_one_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    !(io_rd && io_wr));

  p_locked_reads_ff_r2: assert property (@(posedge clk) disable iff (rst)
    (io_rvalid && $past(locked)) |-> io_rdata == 8'hFF);

  p_no_fwd_locked_r2: assert property (@(posedge clk) disable iff (rst)
    gd_sel |-> !locked);

  p_open_after_key_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> $past(io_wr && io_addr == BASE_ADDR && io_wdata == 8'h87));

  p_exit_locks_r5: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == BASE_ADDR && io_wdata == 8'hAA && !locked) |=> locked);

  p_ldn_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !(io_wr && io_addr == DAT_ADDR && !locked && idx_q == 8'h07) |=> $stable(ldn_q));

  p_fwd_window_r10: assert property (@(posedge clk) disable iff (rst)
    gd_sel |-> (ldn_q == 8'h06 && idx_q >= 8'h30 && io_addr == DAT_ADDR));

  p_fwd_write_r10: assert property (@(posedge clk) disable iff (rst)
    gd_we |-> (gd_sel && io_wr));

  p_rvalid_source_r12: assert property (@(posedge clk) disable iff (rst)
    io_rvalid |-> $past(io_rd && (io_addr == BASE_ADDR || io_addr == DAT_ADDR)));
endmodule

bind sio_cfg_port sio_cfg_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .io_rd     (io_rd),
  .io_wr     (io_wr),
  .io_addr   (io_addr),
  .io_wdata  (io_wdata),
  .io_rdata  (io_rdata),
  .io_rvalid (io_rvalid),
  .gd_sel    (gd_sel),
  .gd_we     (gd_we),
  .locked    (locked),
  .ldn_q     (ldn_q),
  .idx_q     (idx_q)
);

// File: tb/test_sio_cfg_port.sv
module test_sio_cfg_port;
  localparam logic [15:0] B = 16'h002E;
  localparam logic [15:0] D = 16'h002F;

  logic        clk = 1'b0, rst = 1'b1, io_rd = 1'b0, io_wr = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0, io_rdata, gd_idx, gd_wdata, gd_rdata;
  logic        io_rvalid, gd_sel, gd_we;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign gd_rdata = gd_idx ^ 8'h5A;

  sio_cfg_port #(.ADDR_W(16), .BASE_ADDR(B), .DEV_ID(16'h0A55), .REV_ID(8'h11),
                 .MFR_ID(16'h1934), .GPIO_LDN(8'h06)) i_sio_cfg_port (
    .clk(clk), .rst(rst), .io_rd(io_rd), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rvalid(io_rvalid),
    .gd_sel(gd_sel), .gd_we(gd_we), .gd_idx(gd_idx), .gd_wdata(gd_wdata),
    .gd_rdata(gd_rdata));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  bit       m_locked = 1'b1, m_rvalid = 1'b0;
  int       m_cnt = 0;
  logic [7:0] m_idx = '0, m_ldn = '0, m_rdata = '0;

  function automatic logic [7:0] m_read(input logic [15:0] a);
    if (m_locked) return 8'hFF;
    if (a == B) return m_idx;
    if (m_idx >= 8'h30) return (m_ldn == 8'h06) ? (m_idx ^ 8'h5A) : 8'hFF;
    case (m_idx)
      8'h07: return m_ldn;
      8'h20: return 8'h0A;
      8'h21: return 8'h55;
      8'h22: return 8'h11;
      8'h23: return 8'h19;
      8'h24: return 8'h34;
      default: return 8'hFF;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_locked = 1'b1; m_cnt = 0; m_idx = '0; m_ldn = '0; m_rvalid = 1'b0; m_rdata = '0;
    end else begin
      bit nv;
      logic [7:0] nd;
      nv = io_rd && (io_addr == B || io_addr == D);
      nd = nv ? m_read(io_addr) : m_rdata;
      if (io_wr && io_addr == D && !m_locked && m_idx == 8'h07) m_ldn = io_wdata;
      if (io_wr && io_addr == B) begin
        if (m_locked) begin
          if (io_wdata == 8'h87) begin
            if (m_cnt == 1) begin m_locked = 1'b0; m_cnt = 0; end
            else m_cnt = 1;
          end else m_cnt = 0;
        end else if (io_wdata == 8'hAA) m_locked = 1'b1;
        else m_idx = io_wdata;
      end
      m_rvalid = nv;
      m_rdata = nd;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk(io_rvalid == m_rvalid, "R12 rvalid vs model", io_rvalid, m_rvalid);
      if (m_rvalid) chk(io_rdata == m_rdata, "R12 rdata vs model", io_rdata, m_rdata);
      #2;
      begin
        bit es;
        es = (io_rd || io_wr) && io_addr == D && !m_locked && m_idx >= 8'h30 && m_ldn == 8'h06;
        chk(gd_sel == es, "R10 gd_sel vs model", gd_sel, es);
        if (es) chk(gd_we == io_wr && gd_idx == m_idx, "R10 gd_we/gd_idx vs model",
                    {gd_we, gd_idx}, {io_wr, m_idx});
      end
    end
  end

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic rd_expect(input logic [15:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); io_rd = 1'b1; io_addr = a;
    @(negedge clk); io_rd = 1'b0;
    chk(io_rvalid == 1'b1 && io_rdata == exp, tag, {io_rvalid, io_rdata}, {1'b1, exp});
  endtask

  task automatic rd_none(input logic [15:0] a, input string tag);
    @(negedge clk); io_rd = 1'b1; io_addr = a;
    @(negedge clk); io_rd = 1'b0;
    chk(io_rvalid == 1'b0, tag, io_rvalid, 0);
  endtask

  task automatic wr_fwd(input logic [7:0] d, input bit exp_sel, input logic [7:0] exp_idx,
                        input string tag);
    @(negedge clk); io_wr = 1'b1; io_addr = D; io_wdata = d;
    #2;
    chk(gd_sel == exp_sel, tag, gd_sel, exp_sel);
    if (exp_sel) chk(gd_we && gd_idx == exp_idx && gd_wdata == d, tag,
                     {gd_we, gd_idx, gd_wdata}, {1'b1, exp_idx, d});
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic unlock();
    bus_wr(B, 8'h87); bus_wr(B, 8'h87);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    chk(io_rvalid == 1'b0 && gd_sel == 1'b0, "R1 reset outputs", {io_rvalid, gd_sel}, 0);
    rd_expect(D, 8'hFF, "R2 locked data read");
    rd_expect(B, 8'hFF, "R2 locked index read");
    bus_wr(B, 8'h87);
    rd_expect(D, 8'hFF, "R3 single key stays locked");
    bus_wr(B, 8'h87);
    rd_expect(B, 8'h00, "R1 index reset value");
    bus_wr(B, 8'h07);
    rd_expect(D, 8'h00, "R1 ldn reset value");
    rd_expect(B, 8'h07, "R6 index readback");
    bus_wr(B, 8'hAA);
    rd_expect(D, 8'hFF, "R5 exit key locks");
    bus_wr(D, 8'h33);
    bus_wr(B, 8'h3C);
    unlock();
    rd_expect(B, 8'h07, "R5 exit key not stored / R2 locked index write ignored");
    rd_expect(D, 8'h00, "R2 locked data write ignored");
    bus_wr(B, 8'hAA);
    bus_wr(B, 8'h87); bus_wr(B, 8'h55); bus_wr(B, 8'h87);
    rd_expect(D, 8'hFF, "R4 broken key sequence");
    bus_wr(B, 8'h87);
    rd_expect(B, 8'h07, "R4 fresh key pair unlocks");
    rd_none(16'h004E, "R6 other address no rvalid");
    bus_wr(16'h004E, 8'hAA);
    bus_wr(16'h002D, 8'hAA);
    rd_expect(B, 8'h07, "R6 stray address write ignored");
    bus_wr(D, 8'h06);
    rd_expect(D, 8'h06, "R7 ldn write/read");
    bus_wr(B, 8'h20); rd_expect(D, 8'h0A, "R8 device id high");
    bus_wr(B, 8'h21); rd_expect(D, 8'h55, "R8 device id low");
    bus_wr(B, 8'h22); bus_wr(D, 8'h00); rd_expect(D, 8'h11, "R8 revision read-only");
    bus_wr(B, 8'h23); rd_expect(D, 8'h19, "R9 manufacturer high");
    bus_wr(B, 8'h24); rd_expect(D, 8'h34, "R9 manufacturer low");
    bus_wr(B, 8'h2F); rd_expect(D, 8'hFF, "R12 unmapped below bank");
    bus_wr(B, 8'h08); bus_wr(D, 8'h01); rd_expect(D, 8'hFF, "R12 unmapped write ignored");
    bus_wr(B, 8'h2F); wr_fwd(8'h01, 1'b0, 8'h2F, "R12 no forward below 0x30");
    bus_wr(B, 8'h30); wr_fwd(8'h9C, 1'b1, 8'h30, "R10 forward write at 0x30");
    rd_expect(D, 8'h6A, "R10 forward read at 0x30");
    bus_wr(B, 8'hFF); rd_expect(D, 8'hA5, "R10 forward read at 0xFF");
    bus_wr(B, 8'h07); bus_wr(D, 8'h05);
    bus_wr(B, 8'h31); wr_fwd(8'h77, 1'b0, 8'h31, "R11 other device no strobe");
    rd_expect(D, 8'hFF, "R11 other device reads FF");
    bus_wr(B, 8'h07); bus_wr(D, 8'h06); bus_wr(B, 8'h30); bus_wr(B, 8'hAA);
    wr_fwd(8'h12, 1'b0, 8'h30, "R2 no forward while locked");
    rd_expect(D, 8'hFF, "R2 bank read while locked");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R12 actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule